// File: doc/BRIEF.md
# Reset-Sampled Configuration Strap Latch

This block reads a set of hardware configuration straps when a reset sequence ends. The straps arrive on pins that are shared with the address bus and with one control line. The block turns them into stable option bits and holds those bits until the next reset. A strap counts as selected when its pin is driven low while reset is asserted. The option bits are output tri-state, run built-in self-test, ignore machine-check error reports, ignore bus-initialisation reports, a 2-bit cluster identifier and disable bus parking.

The strap pins and the reset line each pass through a two-flop synchroniser. When the synchronised reset is seen rising, the block latches the strap value from the last clock at which reset was still asserted. It then raises `cfg_valid` for one cycle. A warm reset (power-good held high) captures options in the same way as a power-on reset, with one exception: output tri-state is honoured only if power-good was low at some point during that reset sequence. An asserted address strap that is not one of the option pins is reported on `strap_illegal`. Power-good low clears every output at once.

Top module: `strap_cfg_latch`

## Requirements
- R1: While power-good is low, and from then until the first capture, every option output, `strap_illegal` and `cfg_valid` read 0, whatever the strap pins carry.
- R2: On capture, a pin that is low selects its option: `strap_addr_n[3]` gives self-test, bit 9 gives ignore machine-check, bit 10 gives ignore bus-init, bit 15 gives disable parking, and `opt_cluster_id[i]` is the inverse of `strap_addr_n[11+i]`.
- R3: Outputs update and `cfg_valid` is high for exactly one cycle, starting at the third rising clock edge at which `rst_n` is sampled high after being low.
- R4: Between captures the outputs hold their values while straps change, including while a later reset is asserted and before it is released.
- R5: A warm reset (power-good kept high) recaptures every option other than tri-state exactly as a power-on reset would.
- R6: `opt_tristate` is set at capture only when `strap_smi_n` is low and power-good was low since the previous capture. Otherwise it is 0.
- R7: `strap_illegal` is set at capture when any `strap_addr_n` bit other than 3, 9, 10, 11, 12 or 15 is low, and it holds until the next capture.
- R8: Power-good falling clears all outputs without waiting for a clock edge.
- R9: Strap values that change on the same clock as the reset release do not affect the captured options.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset whose release triggers capture |
| pwr_good | input | 1 | Active-high power-good; low clears state |
| strap_smi_n | input | 1 | Active-low control-line strap (tri-state option) |
| strap_addr_n | input | 16 | Active-low address-line straps |
| opt_tristate | output | 1 | Output tri-state selected |
| opt_bist | output | 1 | Built-in self-test selected |
| opt_no_mcerr | output | 1 | Machine-check error observation disabled |
| opt_no_binit | output | 1 | Bus-init observation disabled |
| opt_cluster_id | output | 2 | Cluster identifier |
| opt_no_park | output | 1 | Bus parking disabled |
| strap_illegal | output | 1 | Undefined address strap was asserted |
| cfg_valid | output | 1 | One-cycle pulse after each capture |

## Verification
Straps are drawn at random over all 16 address lines and the control line. Some draws use only legal pins, which shows each option bit mapping on its own. Others use any pin, which separates the illegal flag from the option bits. Resets alternate at random between cold (power-good dropped) and warm, so tri-state honouring can be told apart from plain strap decoding. Directed cases add all pins idle, all pins asserted, and a strap change on the release clock, which shows whether the pre-release sample or the later one was latched. Strap changes between resets and inside an asserted reset show that the outputs hold.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

   localparam int CLUSTER_W = 2;

   typedef struct packed {
      logic                 tristate;
      logic                 bist;
      logic                 no_mcerr;
      logic                 no_binit;
      logic [CLUSTER_W-1:0] cluster;
      logic                 no_park;
   } opt_t;

   localparam opt_t OPT_NONE = '0;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("strap_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("strap_sync width must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/strap_decode.sv
module strap_decode
   import strap_cfg_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter bit ACTIVE_LOW   = 1'b1,
   parameter int POS_BIST     = 3,
   parameter int POS_NO_MCERR = 9,
   parameter int POS_NO_BINIT = 10,
   parameter int POS_CID_LO   = 11,
   parameter int POS_NO_PARK  = 15
) (
   input  logic [ADDR_W-1:0] addr_pin,
   input  logic              smi_pin,
   output opt_t              opt,
   output logic              illegal
);

   function automatic logic [ADDR_W-1:0] legal_mask();
      logic [ADDR_W-1:0] m;
      m = '0;
      m[POS_BIST]     = 1'b1;
      m[POS_NO_MCERR] = 1'b1;
      m[POS_NO_BINIT] = 1'b1;
      m[POS_NO_PARK]  = 1'b1;
      for (int i = 0; i < CLUSTER_W; i++) m[POS_CID_LO+i] = 1'b1;
      return m;
   endfunction

   localparam logic [ADDR_W-1:0] LEGAL = legal_mask();

   logic [ADDR_W-1:0] addr_on;
   logic              smi_on;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign addr_on = ~addr_pin;
         assign smi_on  = ~smi_pin;
      end else begin : g_high
         assign addr_on = addr_pin;
         assign smi_on  = smi_pin;
      end
   endgenerate

   always_comb begin
      opt          = OPT_NONE;
      opt.tristate = smi_on;
      opt.bist     = addr_on[POS_BIST];
      opt.no_mcerr = addr_on[POS_NO_MCERR];
      opt.no_binit = addr_on[POS_NO_BINIT];
      opt.cluster  = addr_on[POS_CID_LO +: CLUSTER_W];
      opt.no_park  = addr_on[POS_NO_PARK];
   end

   assign illegal = |(addr_on & ~LEGAL);

endmodule

// File: rtl/strap_capture.sv
module strap_capture
   import strap_cfg_pkg::*;
(
   input  logic clk,
   input  logic arst_n,
   input  logic rst_level,
   input  opt_t opt_in,
   input  logic illegal_in,
   output opt_t opt_out,
   output logic illegal_out,
   output logic valid
);

   logic rst_q;
   logic pg_dropped;
   opt_t opt_q;
   logic ill_q;
   logic capture;

   // rising synchronised reset level marks the end of a reset sequence
   assign capture = rst_level & ~rst_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         rst_q      <= 1'b0;
         pg_dropped <= 1'b1;
         opt_q      <= OPT_NONE;
         ill_q      <= 1'b0;
         opt_out    <= OPT_NONE;
         illegal_out<= 1'b0;
         valid      <= 1'b0;
      end else begin
         rst_q <= rst_level;
         // one-cycle delay aligns straps with the last asserted reset sample
         opt_q <= opt_in;
         ill_q <= illegal_in;
         valid <= capture;
         if (capture) begin
            opt_out          <= opt_q;
            opt_out.tristate <= opt_q.tristate & pg_dropped;
            illegal_out      <= ill_q;
            pg_dropped       <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
   import strap_cfg_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit ACTIVE_LOW   = 1'b1,
   parameter int POS_BIST     = 3,
   parameter int POS_NO_MCERR = 9,
   parameter int POS_NO_BINIT = 10,
   parameter int POS_CID_LO   = 11,
   parameter int POS_NO_PARK  = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwr_good,
   input  logic                 strap_smi_n,
   input  logic [ADDR_W-1:0]    strap_addr_n,
   output logic                 opt_tristate,
   output logic                 opt_bist,
   output logic                 opt_no_mcerr,
   output logic                 opt_no_binit,
   output logic [CLUSTER_W-1:0] opt_cluster_id,
   output logic                 opt_no_park,
   output logic                 strap_illegal,
   output logic                 cfg_valid
);

   localparam int             SW        = ADDR_W + 1;
   localparam logic [SW-1:0]  STRAP_IDLE = ACTIVE_LOW ? {SW{1'b1}} : {SW{1'b0}};
   localparam int             CID_TOP   = POS_CID_LO + CLUSTER_W - 1;

   generate
      if (POS_NO_PARK >= ADDR_W || CID_TOP >= ADDR_W ||
          POS_NO_BINIT >= ADDR_W || POS_NO_MCERR >= ADDR_W || POS_BIST >= ADDR_W) begin : g_bad_pos
         $error("strap position outside the address strap range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchroniser stages required");
      end
   endgenerate

   logic          blk_rst_n;
   logic          rst_level;
   logic [SW-1:0] strap_sync_q;
   opt_t          opt_dec;
   logic          ill_dec;
   opt_t          opt_cur;

   // power-good asserts clear asynchronously and releases synchronously
   strap_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
      .clk    (clk),
      .arst_n (pwr_good),
      .d      (1'b1),
      .q      (blk_rst_n)
   );

   strap_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk    (clk),
      .arst_n (blk_rst_n),
      .d      (rst_n),
      .q      (rst_level)
   );

   strap_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(STRAP_IDLE)) u_strap_sync (
      .clk    (clk),
      .arst_n (blk_rst_n),
      .d      ({strap_smi_n, strap_addr_n}),
      .q      (strap_sync_q)
   );

   strap_decode #(
      .ADDR_W       (ADDR_W),
      .ACTIVE_LOW   (ACTIVE_LOW),
      .POS_BIST     (POS_BIST),
      .POS_NO_MCERR (POS_NO_MCERR),
      .POS_NO_BINIT (POS_NO_BINIT),
      .POS_CID_LO   (POS_CID_LO),
      .POS_NO_PARK  (POS_NO_PARK)
   ) u_dec (
      .addr_pin (strap_sync_q[ADDR_W-1:0]),
      .smi_pin  (strap_sync_q[ADDR_W]),
      .opt      (opt_dec),
      .illegal  (ill_dec)
   );

   strap_capture u_cap (
      .clk         (clk),
      .arst_n      (blk_rst_n),
      .rst_level   (rst_level),
      .opt_in      (opt_dec),
      .illegal_in  (ill_dec),
      .opt_out     (opt_cur),
      .illegal_out (strap_illegal),
      .valid       (cfg_valid)
   );

   assign opt_tristate   = opt_cur.tristate;
   assign opt_bist       = opt_cur.bist;
   assign opt_no_mcerr   = opt_cur.no_mcerr;
   assign opt_no_binit   = opt_cur.no_binit;
   assign opt_cluster_id = opt_cur.cluster;
   assign opt_no_park    = opt_cur.no_park;

endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk #(
   parameter int CID_W = 2
) (
   input logic             clk,
   input logic             pwr_good,
   input logic             opt_tristate,
   input logic             opt_bist,
   input logic             opt_no_mcerr,
   input logic             opt_no_binit,
   input logic [CID_W-1:0] opt_cluster_id,
   input logic             opt_no_park,
   input logic             strap_illegal,
   input logic             cfg_valid
);

   logic             seen;
   logic             pg_low_since;
   logic [CID_W+5:0] bundle;

   assign bundle = {opt_tristate, opt_bist, opt_no_mcerr, opt_no_binit,
                    opt_cluster_id, opt_no_park, strap_illegal};

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         seen         <= 1'b0;
         pg_low_since <= 1'b1;
      end else if (cfg_valid) begin
         seen         <= 1'b1;
         pg_low_since <= 1'b0;
      end
   end

   AST_ZERO_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!pwr_good)
      (!seen && !cfg_valid) |-> (bundle == '0)); // R1

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!pwr_good)
      cfg_valid |=> !cfg_valid); // R3

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!pwr_good)
      !cfg_valid |-> $stable(bundle)); // R4

   AST_TRISTATE_WARM: assert property (@(posedge clk) disable iff (!pwr_good)
      (cfg_valid && !pg_low_since) |-> !opt_tristate); // R6

   AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!pwr_good)
      !cfg_valid |-> $stable(strap_illegal)); // R7

endmodule

bind strap_cfg_latch strap_cfg_chk #(.CID_W(strap_cfg_pkg::CLUSTER_W)) u_chk (
   .clk            (clk),
   .pwr_good       (pwr_good),
   .opt_tristate   (opt_tristate),
   .opt_bist       (opt_bist),
   .opt_no_mcerr   (opt_no_mcerr),
   .opt_no_binit   (opt_no_binit),
   .opt_cluster_id (opt_cluster_id),
   .opt_no_park    (opt_no_park),
   .strap_illegal  (strap_illegal),
   .cfg_valid      (cfg_valid)
);

// File: tb/sim_strap_cfg_latch.sv
`timescale 1ns/1ps
module sim_strap_cfg_latch;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pwr_good;
   logic        strap_smi_n;
   logic [15:0] strap_addr_n;
   logic        opt_tristate, opt_bist, opt_no_mcerr, opt_no_binit, opt_no_park;
   logic [1:0]  opt_cluster_id;
   logic        strap_illegal, cfg_valid;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [7:0] cur;      // expected held outputs
   bit         pgd;      // power-good dropped since last capture

   always #10 clk = ~clk;   // 50 MHz

   strap_cfg_latch u0 (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .strap_smi_n(strap_smi_n), .strap_addr_n(strap_addr_n),
      .opt_tristate(opt_tristate), .opt_bist(opt_bist),
      .opt_no_mcerr(opt_no_mcerr), .opt_no_binit(opt_no_binit),
      .opt_cluster_id(opt_cluster_id), .opt_no_park(opt_no_park),
      .strap_illegal(strap_illegal), .cfg_valid(cfg_valid)
   );

   function automatic logic [7:0] obs();
      return {opt_tristate, opt_bist, opt_no_mcerr, opt_no_binit,
              opt_cluster_id, opt_no_park, strap_illegal};
   endfunction

   function automatic logic [7:0] expect_opts(logic [15:0] a_n, logic s_n, bit dropped);
      logic [15:0] on;
      on = ~a_n;
      return {~s_n & dropped, on[3], on[9], on[10], on[12:11], on[15],
              |(on & ~16'h9E08)};
   endfunction

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
      end
   endtask

   // release reset with straps a/s present, scramble them on the release clock
   task automatic release_check(logic [15:0] a, logic s, string req);
      logic [7:0] nxt;
      nxt = expect_opts(a, s, pgd);
      @(negedge clk);
      rst_n        = 1'b1;
      strap_addr_n = 16'($urandom);   // R9: later values must not be taken
      strap_smi_n  = 1'($urandom);
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk("R4 hold before update", obs(), cur);
      chk("R3 no early valid", {7'd0, cfg_valid}, 8'd0);
      @(posedge clk);
      @(negedge clk);
      chk(req, obs(), nxt);
      chk("R3 valid pulse", {7'd0, cfg_valid}, 8'd1);
      cur = nxt;
      pgd = 1'b0;
      @(negedge clk);
      chk("R3 valid single cycle", {7'd0, cfg_valid}, 8'd0);
      chk("R4 hold after capture", obs(), cur);
   endtask

   task automatic reset_cycle(logic [15:0] a, logic s, bit drop, string req);
      @(negedge clk);
      rst_n        = 1'b0;
      strap_addr_n = a;
      strap_smi_n  = s;
      if (drop) begin
         pwr_good = 1'b0;
         #1;
         cur = 8'd0;
         chk("R8 async clear", obs(), 8'd0);
         pgd = 1'b1;
         repeat (3) @(negedge clk);
         pwr_good = 1'b1;
      end
      repeat (4) @(negedge clk);
      chk("R4 hold during reset", obs(), cur);
      release_check(a, s, req);
   endtask

   initial begin
      rst_n        = 1'b0;
      pwr_good     = 1'b0;
      strap_smi_n  = 1'b0;
      strap_addr_n = 16'h0000;
      cur          = 8'd0;
      pgd          = 1'b1;
      void'($urandom(32'd2718));

      repeat (3) @(negedge clk);
      chk("R1 zero with power-good low", obs(), 8'd0);
      chk("R1 valid low", {7'd0, cfg_valid}, 8'd0);
      pwr_good = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 zero before first capture", obs(), 8'd0);

      // first capture: every pin asserted, power-on sequence
      release_check(16'h0000, 1'b0, "R2 R6 R7 all asserted cold");

      // straps wander between resets
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         strap_addr_n = 16'($urandom);
         strap_smi_n  = 1'($urandom);
         chk("R4 hold while straps change", obs(), cur);
      end

      // directed: all idle warm, then all asserted warm
      reset_cycle(16'hFFFF, 1'b1, 1'b0, "R2 all idle warm");
      reset_cycle(16'h0000, 1'b0, 1'b0, "R5 R6 all asserted warm");
      reset_cycle(16'h0000, 1'b0, 1'b1, "R6 all asserted cold");
      // single illegal pin alone
      reset_cycle(16'hFFFE, 1'b1, 1'b0, "R7 lone illegal pin");
      // cluster id patterns
      reset_cycle(16'hF7FF, 1'b1, 1'b0, "R2 cluster id 1");
      reset_cycle(16'hEFFF, 1'b1, 1'b1, "R2 cluster id 2");

      for (int i = 0; i < 40; i++) begin
         logic [15:0] a;
         logic        s;
         bit          drop;
         a = 16'($urandom);
         if ($urandom % 2 == 0) a = a | ~16'h9E08;
         s    = 1'($urandom);
         drop = 1'($urandom);
         reset_cycle(a, s, drop, drop ? "R2 R6 R7 random cold" : "R5 R7 random warm");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule